// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block sits between a host's asynchronous parallel bus and the internal operation engine of a NOR flash model. The host writes bytes by pulsing a write strobe while the chip select is low. The block captures the address when the strobe falls and the data when it rises. It then feeds each completed write cycle to a command decoder. The decoder only recognises a command after a two-cycle unlock handshake. Programming takes one more command byte followed by a target write. Erasing takes a longer six-cycle handshake that ends in either a whole-array erase or an erase of one sector.

While an operation runs, the block locks out commands. A program or a whole-array erase ignores every write. A sector erase accepts only a suspend byte, and once suspended only a resume byte. Host reads return one of two things. In read mode they return array contents. While busy they return a status byte, which holds a completion-polling bit in bit 7 and a bit in bit 6 that flips after every status read. The array is modelled as a small memory inside the engine. Programming can only clear bits, and erasing sets every word of its range to all-ones, one word per clock.

Decoder states: `D_READ` (array read mode), `D_UNLK_A` and `D_UNLK_B` (first and second unlock cycle seen), `D_PROG_SET` (program armed), `D_ERA_SET`, `D_ERA_UNLK_A`, `D_ERA_UNLK_B` (erase armed, then its second unlock pair), `D_PROG_RUN`, `D_CHIP_RUN`, `D_SECT_RUN` (operation running), `D_SUSPENDED` (sector erase on hold). The transitions are as follows.
- `D_READ`→`D_UNLK_A` on AAh at 555h.
- `D_UNLK_A`→`D_UNLK_B` on 55h at 2AAh.
- `D_UNLK_B`→`D_PROG_SET` on A0h at 555h, or →`D_ERA_SET` on 80h at 555h.
- `D_PROG_SET`→`D_PROG_RUN` on any write.
- `D_ERA_SET`→`D_ERA_UNLK_A`→`D_ERA_UNLK_B` on the same unlock pair.
- `D_ERA_UNLK_B`→`D_CHIP_RUN` on 10h at 555h, or →`D_SECT_RUN` on 30h at any address.
- Any other write in an unlock or armed-erase state returns to `D_READ`.
- The three run states return to `D_READ` on engine completion.
- `D_SECT_RUN`→`D_SUSPENDED` on B0h.
- `D_SUSPENDED`→`D_SECT_RUN` on 30h, or →`D_READ` on completion.

Top module: `flash_cmd_front`

## Requirements
- R1: After reset, `busy` is low and `dq_oe` is low, and the decoder is in array read mode.
- R2: A write cycle uses the address present when `bus_wr_n` falls and the data present when it rises, both with `bus_cs_n` low. Address changes after the falling edge have no effect.
- R3: The sequence AAh@555h, 55h@2AAh, A0h@555h, then data D at address X holds `busy` high for PROG_CYCLES clocks. After that, word X reads as its old value AND D.
- R4: A write that breaks an unlock or armed sequence returns the decoder to read mode. A following command or data write then leaves the array unchanged.
- R5: Writing F0h during a partial unlock returns the decoder to read mode. The array is not touched.
- R6: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h sets every word of the array to FFh.
- R7: The same erase sequence ending with 30h at address X sets to FFh only the words whose top SECT_BITS address bits equal those of X.
- R8: While a program or a whole-array erase runs, every write is ignored: `busy` stays high and no other word changes.
- R9: While a sector erase runs, only B0h (any address) is honoured. It drops `busy` within one write cycle, holds the erase, and returns array data on reads. A later 30h resumes the erase to completion, and other bytes such as F0h are ignored.
- R10: While `busy`, reads return a status byte. Bit 7 is the complement of bit 7 of the data being programmed, or 0 during erase. Bit 6 flips after each status read. Bits 5:0 are zero.
- R11: Once the engine finishes, `busy` falls on the next clock. Reads return array data and the full command set is accepted again.
- R12: `dq_oe` is high only while `bus_cs_n` and `bus_rd_n` are low and `bus_wr_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_rd_n | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| dq_in | input | DQ_W | Write data from host |
| dq_out | output | DQ_W | Array data or status byte |
| dq_oe | output | 1 | Read data valid / drive enable |
| busy | output | 1 | High while a program or erase runs (not while suspended) |

## Verification
The bench keeps ADDR_W=11, so the unlock addresses 555h and 2AAh decode exactly, and SECT_BITS=2, which gives 512-word sectors. A whole-array erase then lasts about 2048 clocks, and a suspend lands a few words into a sector walk, which makes a held erase observable at the sector's last word. PROG_CYCLES is raised to 64 so that a complete four-write program sequence and a suspend byte both fit inside one running program. The lockout of R8 can therefore be exercised with real command traffic rather than a single stray write.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

    localparam int UNLK_W = 11;

    localparam logic [UNLK_W-1:0] UNLK_ADDR_1 = 11'h555;
    localparam logic [UNLK_W-1:0] UNLK_ADDR_2 = 11'h2AA;

    localparam logic [7:0] CMD_UNLK_1 = 8'hAA;
    localparam logic [7:0] CMD_UNLK_2 = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESUME = 8'h30;

    typedef enum logic [3:0] {
        D_READ,
        D_UNLK_A,
        D_UNLK_B,
        D_PROG_SET,
        D_ERA_SET,
        D_ERA_UNLK_A,
        D_ERA_UNLK_B,
        D_PROG_RUN,
        D_CHIP_RUN,
        D_SECT_RUN,
        D_SUSPENDED
    } dec_state_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_PROG,
        ENG_ERASE
    } eng_state_t;

endpackage

// File: rtl/fcf_bus_capture.sv
`timescale 1ns/1ps
module fcf_bus_capture #(
    parameter int ADDR_W = 11,
    parameter int DQ_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data
);

    logic              wr_q;
    logic [ADDR_W-1:0] addr_lat;
    logic              strobe_fall;
    logic              strobe_rise;

    always_comb begin
        strobe_fall = !bus_cs_n && wr_q && !bus_wr_n;
        strobe_rise = !bus_cs_n && !wr_q && bus_wr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q     <= 1'b1;
            addr_lat <= '0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_q   <= bus_wr_n;
            wr_stb <= strobe_rise;
            if (strobe_fall) begin
                addr_lat <= addr;
            end
            if (strobe_rise) begin
                wr_addr <= addr_lat;
                wr_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/fcf_cmd_decoder.sv
`timescale 1ns/1ps
module fcf_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DQ_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic              eng_done,
    output logic              start_prog,
    output logic              start_chip,
    output logic              start_sect,
    output logic              suspend_req,
    output logic              resume_req,
    output logic              stat_mode,
    output logic              prog_mode
);

    dec_state_t st;
    dec_state_t nxt;

    logic [7:0] cmd;
    logic       at_first;
    logic       at_second;
    logic       is_unlk1;
    logic       is_unlk2;

    always_comb begin
        cmd       = wr_data[7:0];
        at_first  = (wr_addr[UNLK_W-1:0] == UNLK_ADDR_1);
        at_second = (wr_addr[UNLK_W-1:0] == UNLK_ADDR_2);
        is_unlk1  = at_first  && (cmd == CMD_UNLK_1);
        is_unlk2  = at_second && (cmd == CMD_UNLK_2);
    end

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            D_READ: begin
                if (wr_stb && is_unlk1) nxt = D_UNLK_A;
            end
            D_UNLK_A: begin
                if (wr_stb) nxt = is_unlk2 ? D_UNLK_B : D_READ;
            end
            D_UNLK_B: begin
                if (wr_stb) begin
                    if (at_first && cmd == CMD_PROG)       nxt = D_PROG_SET;
                    else if (at_first && cmd == CMD_ERASE) nxt = D_ERA_SET;
                    else                                   nxt = D_READ;
                end
            end
            D_PROG_SET: begin
                if (wr_stb) nxt = D_PROG_RUN;
            end
            D_ERA_SET: begin
                if (wr_stb) nxt = is_unlk1 ? D_ERA_UNLK_A : D_READ;
            end
            D_ERA_UNLK_A: begin
                if (wr_stb) nxt = is_unlk2 ? D_ERA_UNLK_B : D_READ;
            end
            D_ERA_UNLK_B: begin
                if (wr_stb) begin
                    if (at_first && cmd == CMD_CHIP) nxt = D_CHIP_RUN;
                    else if (cmd == CMD_SECT)        nxt = D_SECT_RUN;
                    else                             nxt = D_READ;
                end
            end
            D_PROG_RUN, D_CHIP_RUN: begin
                if (eng_done) nxt = D_READ;
            end
            D_SECT_RUN: begin
                if (eng_done)                         nxt = D_READ;
                else if (wr_stb && cmd == CMD_SUSP)   nxt = D_SUSPENDED;
            end
            D_SUSPENDED: begin
                if (eng_done)                         nxt = D_READ;
                else if (wr_stb && cmd == CMD_RESUME) nxt = D_SECT_RUN;
            end
            default: nxt = D_READ;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= D_READ;
        else        st <= nxt;
    end

    // outputs
    always_comb begin
        start_prog  = (st == D_PROG_SET) && wr_stb;
        start_chip  = (st == D_ERA_UNLK_B) && (nxt == D_CHIP_RUN);
        start_sect  = (st == D_ERA_UNLK_B) && (nxt == D_SECT_RUN);
        suspend_req = (st == D_SECT_RUN) && (nxt == D_SUSPENDED);
        resume_req  = (st == D_SUSPENDED) && (nxt == D_SECT_RUN);
        stat_mode   = (st == D_PROG_RUN) || (st == D_CHIP_RUN) || (st == D_SECT_RUN);
        prog_mode   = (st == D_PROG_RUN);
    end

endmodule

// File: rtl/fcf_op_engine.sv
`timescale 1ns/1ps
module fcf_op_engine
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int DQ_W        = 8,
    parameter int SECT_BITS   = 2,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_prog,
    input  logic              start_chip,
    input  logic              start_sect,
    input  logic              suspend_req,
    input  logic              resume_req,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DQ_W-1:0]   op_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DQ_W-1:0]   rd_data,
    output logic              running,
    output logic              sect_op,
    output logic              done,
    output logic              poll_ref
);

    localparam int WORDS      = 1 << ADDR_W;
    localparam int OFS_W      = ADDR_W - SECT_BITS;
    localparam int SECT_WORDS = 1 << OFS_W;
    localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

    eng_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DQ_W-1:0]   tgt_data;
    logic [ADDR_W-1:0] idx;
    logic [ADDR_W-1:0] remain;
    logic              held;

    logic [DQ_W-1:0]   mem [WORDS];

    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [DQ_W-1:0]   mem_wd;

    // array write port: program clears bits, erase sets the whole word
    always_comb begin
        mem_we = 1'b0;
        mem_wa = idx;
        mem_wd = '1;
        unique case (st)
            ENG_PROG: begin
                if (cnt == '0) begin
                    mem_we = 1'b1;
                    mem_wa = tgt_addr;
                    mem_wd = mem[tgt_addr] & tgt_data;
                end
            end
            ENG_ERASE: begin
                mem_we = !held;
            end
            default: mem_we = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_wa] <= mem_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ENG_IDLE;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= '0;
            idx      <= '0;
            remain   <= '0;
            held     <= 1'b0;
            sect_op  <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ENG_IDLE: begin
                    held <= 1'b0;
                    if (start_prog) begin
                        st       <= ENG_PROG;
                        cnt      <= CNT_W'(PROG_CYCLES - 1);
                        tgt_addr <= op_addr;
                        tgt_data <= op_data;
                    end else if (start_chip) begin
                        st      <= ENG_ERASE;
                        idx     <= '0;
                        remain  <= ADDR_W'(WORDS - 1);
                        sect_op <= 1'b0;
                    end else if (start_sect) begin
                        st      <= ENG_ERASE;
                        idx     <= {op_addr[ADDR_W-1 -: SECT_BITS], {OFS_W{1'b0}}};
                        remain  <= ADDR_W'(SECT_WORDS - 1);
                        sect_op <= 1'b1;
                    end
                end
                ENG_PROG: begin
                    if (cnt == '0) begin
                        st   <= ENG_IDLE;
                        done <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ENG_ERASE: begin
                    if (suspend_req)     held <= 1'b1;
                    else if (resume_req) held <= 1'b0;
                    if (!held) begin
                        if (remain == '0) begin
                            st      <= ENG_IDLE;
                            done    <= 1'b1;
                            sect_op <= 1'b0;
                        end else begin
                            idx    <= idx + 1'b1;
                            remain <= remain - 1'b1;
                        end
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_data  = mem[rd_addr];
        running  = (st != ENG_IDLE);
        poll_ref = tgt_data[7];
    end

endmodule

// File: rtl/fcf_read_path.sv
`timescale 1ns/1ps
module fcf_read_path #(
    parameter int DQ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_cs_n,
    input  logic            bus_rd_n,
    input  logic            bus_wr_n,
    input  logic            stat_mode,
    input  logic            prog_mode,
    input  logic            poll_ref,
    input  logic [DQ_W-1:0] arr_data,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe
);

    logic            rd_act;
    logic            rd_q;
    logic            tog;
    logic [DQ_W-1:0] status;

    always_comb begin
        rd_act    = !bus_cs_n && !bus_rd_n && bus_wr_n;
        status    = '0;
        status[7] = prog_mode ? !poll_ref : 1'b0;
        status[6] = tog;
        if (!rd_act)        dq_out = '0;
        else if (stat_mode) dq_out = status;
        else                dq_out = arr_data;
        dq_oe = rd_act;
    end

    // the toggle bit advances at the end of every status read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            tog  <= 1'b0;
        end else begin
            rd_q <= rd_act;
            if (rd_q && !rd_act && stat_mode) tog <= !tog;
        end
    end

endmodule

// File: rtl/flash_cmd_front.sv
`timescale 1ns/1ps
module flash_cmd_front #(
    parameter int ADDR_W      = 11,
    parameter int DQ_W        = 8,
    parameter int SECT_BITS   = 2,
    parameter int PROG_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    output logic              busy
);

    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [DQ_W-1:0]   wr_data;
    logic              start_prog;
    logic              start_chip;
    logic              start_sect;
    logic              suspend_req;
    logic              resume_req;
    logic              stat_mode;
    logic              prog_mode;
    logic [DQ_W-1:0]   arr_data;
    logic              eng_running;
    logic              eng_sect;
    logic              eng_done;
    logic              poll_ref;

    fcf_bus_capture #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_cs_n (bus_cs_n),
        .bus_wr_n (bus_wr_n),
        .addr     (addr),
        .dq_in    (dq_in),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    fcf_cmd_decoder #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .eng_done    (eng_done),
        .start_prog  (start_prog),
        .start_chip  (start_chip),
        .start_sect  (start_sect),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .stat_mode   (stat_mode),
        .prog_mode   (prog_mode)
    );

    fcf_op_engine #(
        .ADDR_W      (ADDR_W),
        .DQ_W        (DQ_W),
        .SECT_BITS   (SECT_BITS),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (start_prog),
        .start_chip  (start_chip),
        .start_sect  (start_sect),
        .suspend_req (suspend_req),
        .resume_req  (resume_req),
        .op_addr     (wr_addr),
        .op_data     (wr_data),
        .rd_addr     (addr),
        .rd_data     (arr_data),
        .running     (eng_running),
        .sect_op     (eng_sect),
        .done        (eng_done),
        .poll_ref    (poll_ref)
    );

    fcf_read_path #(.DQ_W(DQ_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cs_n  (bus_cs_n),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .stat_mode (stat_mode),
        .prog_mode (prog_mode),
        .poll_ref  (poll_ref),
        .arr_data  (arr_data),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    always_comb busy = stat_mode;

endmodule

// File: rtl/flash_cmd_front_chk.sv
`timescale 1ns/1ps
module flash_cmd_front_chk #(
    parameter int DQ_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_cs_n,
    input logic            bus_wr_n,
    input logic            bus_rd_n,
    input logic [DQ_W-1:0] dq_out,
    input logic            dq_oe,
    input logic            busy,
    input logic            start_any,
    input logic            eng_running,
    input logic            eng_sect,
    input logic            eng_done,
    input logic            suspend_req
);

    // R12
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!bus_cs_n && !bus_rd_n && bus_wr_n))
        else $error("drive_window_chk");

    // R8
    no_start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_any |-> !eng_running)
        else $error("no_start_while_busy_chk");

    // R9
    suspend_only_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> eng_sect)
        else $error("suspend_only_sector_chk");

    // R9
    suspend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |=> !busy)
        else $error("suspend_release_chk");

    // R11
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !busy)
        else $error("done_release_chk");

    // R10
    status_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && busy) |-> (dq_out[5:0] == 6'd0))
        else $error("status_low_bits_chk");

endmodule

bind flash_cmd_front flash_cmd_front_chk #(.DQ_W(DQ_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_cs_n    (bus_cs_n),
    .bus_wr_n    (bus_wr_n),
    .bus_rd_n    (bus_rd_n),
    .dq_out      (dq_out),
    .dq_oe       (dq_oe),
    .busy        (busy),
    .start_any   (start_prog | start_chip | start_sect),
    .eng_running (eng_running),
    .eng_sect    (eng_sect),
    .eng_done    (eng_done),
    .suspend_req (suspend_req)
);

// File: tb/tb_flash_cmd_front.sv
`timescale 1ns/1ps
module tb_flash_cmd_front;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int SB = 2;
    localparam int PC = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_cs_n = 1'b1;
    logic          bus_wr_n = 1'b1;
    logic          bus_rd_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          busy;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } sb_item_t;

    sb_item_t   sb[$];
    logic [7:0] rd_val;
    event       rd_ev;

    always #2.5 clk = ~clk;

    flash_cmd_front #(
        .ADDR_W(AW), .DQ_W(DW), .SECT_BITS(SB), .PROG_CYCLES(PC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; bus_cs_n = 1'b0; dq_in = ~d;
        @(negedge clk); bus_wr_n = 1'b0;
        @(negedge clk); addr = ~a; dq_in = d;
        @(negedge clk); bus_wr_n = 1'b1;
        @(negedge clk); bus_cs_n = 1'b1; dq_in = ~d;
        @(negedge clk);
    endtask

    task automatic rd_raw(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk); v = dq_out;
        bus_rd_n = 1'b1; bus_cs_n = 1'b1;
        @(negedge clk);
    endtask

    // driver side of the scoreboard
    task automatic expect_rd(input logic [AW-1:0] a, input logic [7:0] exp,
                             input logic [7:0] mask, input string tag);
        sb_item_t it;
        logic [7:0] v;
        it.exp = exp; it.mask = mask; it.tag = tag;
        sb.push_back(it);
        rd_raw(a, v);
        rd_val = v;
        -> rd_ev;
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            sb_item_t it;
            @(rd_ev);
            it = sb.pop_front();
            chk(((rd_val ^ it.exp) & it.mask) == 8'h00, it.tag, rd_val, it.exp);
        end
    end

    task automatic unlock();
        bus_wr(11'h555, 8'hAA);
        bus_wr(11'h2AA, 8'h55);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        unlock();
        bus_wr(11'h555, 8'hA0);
        bus_wr(a, d);
    endtask

    task automatic erase_pre();
        unlock();
        bus_wr(11'h555, 8'h80);
        unlock();
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v1;
        logic [7:0] v2;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", {7'd0, busy}, 8'h00);
        chk(dq_oe == 1'b0, "R1 dq_oe after reset", {7'd0, dq_oe}, 8'h00);

        // R12: drive window
        addr = 11'h000; bus_cs_n = 1'b0; bus_rd_n = 1'b0;
        @(negedge clk);
        chk(dq_oe == 1'b1, "R12 dq_oe during read", {7'd0, dq_oe}, 8'h01);
        bus_cs_n = 1'b1;
        @(negedge clk);
        chk(dq_oe == 1'b0, "R12 dq_oe with select high", {7'd0, dq_oe}, 8'h00);
        bus_rd_n = 1'b1;

        // R6: whole-array erase, with R10 status and R8 lockout while it runs
        erase_pre();
        bus_wr(11'h555, 8'h10);
        chk(busy == 1'b1, "R6 busy after chip erase", {7'd0, busy}, 8'h01);
        expect_rd(11'h000, 8'h00, 8'hBF, "R10 erase status byte");
        rd_raw(11'h000, v1);
        rd_raw(11'h000, v2);
        chk(v1[6] != v2[6], "R10 toggle bit flips", v2, {v2[7], ~v1[6], v2[5:0]});
        bus_wr(11'h555, 8'hB0);
        chk(busy == 1'b1, "R8 suspend ignored in chip erase", {7'd0, busy}, 8'h01);
        wait_ready();
        expect_rd(11'h000, 8'hFF, 8'hFF, "R6 word 000 erased");
        expect_rd(11'h3A5, 8'hFF, 8'hFF, "R6 word 3A5 erased");
        expect_rd(11'h7FF, 8'hFF, 8'hFF, "R6 word 7FF erased");

        // R3 / R2 / R10 / R11: program
        prog(11'h123, 8'h5A);
        chk(busy == 1'b1, "R3 busy during program", {7'd0, busy}, 8'h01);
        expect_rd(11'h123, 8'h80, 8'hBF, "R10 program polling bit");
        wait_ready();
        expect_rd(11'h123, 8'h5A, 8'hFF, "R3 R2 programmed word");
        prog(11'h123, 8'hF0);
        wait_ready();
        expect_rd(11'h123, 8'h50, 8'hFF, "R3 program only clears bits");

        // R8: full command sequence during a program is ignored
        prog(11'h200, 8'h0F);
        prog(11'h201, 8'h00);
        bus_wr(11'h000, 8'hB0);
        chk(busy == 1'b1, "R8 still busy after commands", {7'd0, busy}, 8'h01);
        wait_ready();
        expect_rd(11'h200, 8'h0F, 8'hFF, "R8 first program done");
        expect_rd(11'h201, 8'hFF, 8'hFF, "R8 locked-out program ignored");

        // R4: broken unlock sequences
        bus_wr(11'h555, 8'hAA);
        bus_wr(11'h2AB, 8'h55);
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h123, 8'h00);
        chk(busy == 1'b0, "R4 no operation after bad unlock", {7'd0, busy}, 8'h00);
        expect_rd(11'h123, 8'h50, 8'hFF, "R4 word unchanged (address mismatch)");
        unlock();
        bus_wr(11'h555, 8'hA1);
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h123, 8'h00);
        expect_rd(11'h123, 8'h50, 8'hFF, "R4 word unchanged (command mismatch)");

        // R5: reset byte inside a partial unlock
        bus_wr(11'h555, 8'hAA);
        bus_wr(11'h000, 8'hF0);
        bus_wr(11'h2AA, 8'h55);
        bus_wr(11'h555, 8'hA0);
        bus_wr(11'h123, 8'h00);
        chk(busy == 1'b0, "R5 idle after reset byte", {7'd0, busy}, 8'h00);
        expect_rd(11'h123, 8'h50, 8'hFF, "R5 word unchanged");

        // R11: full command set usable again
        prog(11'h124, 8'h12);
        wait_ready();
        expect_rd(11'h124, 8'h12, 8'hFF, "R11 new program accepted");

        // R7: sector erase touches only its sector
        prog(11'h400, 8'h44);
        wait_ready();
        erase_pre();
        bus_wr(11'h2AB, 8'h30);
        chk(busy == 1'b1, "R7 busy after sector erase", {7'd0, busy}, 8'h01);
        wait_ready();
        expect_rd(11'h200, 8'hFF, 8'hFF, "R7 sector 1 word 200 erased");
        expect_rd(11'h201, 8'hFF, 8'hFF, "R7 sector 1 word 201 erased");
        expect_rd(11'h123, 8'h50, 8'hFF, "R7 sector 0 untouched");
        expect_rd(11'h400, 8'h44, 8'hFF, "R7 sector 2 untouched");

        // R9: suspend and resume of a sector erase
        prog(11'h1FF, 8'h33);
        wait_ready();
        erase_pre();
        bus_wr(11'h010, 8'h30);
        bus_wr(11'h555, 8'hF0);
        chk(busy == 1'b1, "R9 non-suspend byte ignored", {7'd0, busy}, 8'h01);
        bus_wr(11'h555, 8'hB0);
        chk(busy == 1'b0, "R9 busy drops on suspend", {7'd0, busy}, 8'h00);
        expect_rd(11'h1FF, 8'h33, 8'hFF, "R9 array read while suspended");
        repeat (700) @(negedge clk);
        chk(busy == 1'b0, "R9 stays suspended", {7'd0, busy}, 8'h00);
        expect_rd(11'h1FF, 8'h33, 8'hFF, "R9 erase held while suspended");
        bus_wr(11'h000, 8'h30);
        chk(busy == 1'b1, "R9 busy on resume", {7'd0, busy}, 8'h01);
        wait_ready();
        expect_rd(11'h1FF, 8'hFF, 8'hFF, "R9 erase completes after resume");
        expect_rd(11'h123, 8'hFF, 8'hFF, "R9 sector 0 word 123 erased");
        expect_rd(11'h400, 8'h44, 8'hFF, "R7 other sector kept across resume");

        repeat (4) @(negedge clk);
        while (sb.size() != 0) @(negedge clk);
        summary();
        $finish;
    end

endmodule